// File: doc/BRIEF.md
# Dual-Target Two-Wire Serial Slave Interface

This block is the bus-facing half of a peripheral that carries two separate address spaces behind one pair of two-wire serial pins: a temperature-sensor register file and a non-volatile memory array. It watches SCL and SDA from the system clock domain and cleans both lines. It finds START and STOP conditions and collects the first byte after each START. The upper four bits of that byte choose the target space, and the next three bits must equal the strap pins. When both match, the block acknowledges and then streams bytes to or from a register back end through single-cycle strobes.

The back end sees three pulses. The first reports a matched address, with the chosen target and the direction. The second delivers each received write byte. The third asks for the next byte to transmit, which the back end must present on `rd_data_i` before the next falling SCL edge. Up to eight such slaves can share one bus, because each one carries its own strap setting.

Top module: `i2c_dual_target_slave`

## Requirements
- R1: After reset `sda_pull_o`, `addr_hit_o`, `wr_valid_o` and `rd_req_o` are all 0.
- R2: Bus activity seen before any START condition (SDA falling while SCL is high) is ignored. There is no acknowledge and no strobe.
- R3: After a START, a first byte whose bits [7:4] are 0011 and whose bits [3:1] equal `strap_i` is acknowledged. The block holds SDA low through the 9th SCL clock. It also pulses `addr_hit_o` with `target_o`=0 (sensor registers) and `rw_o` equal to bit [0], where 1 means read.
- R4: A first byte with bits [7:4] = 1010 and matching straps is acknowledged in the same way, with `target_o`=1 (memory).
- R5: Any other prefix, or any strap mismatch, gets no acknowledge. Nothing more is acknowledged or strobed until the next START.
- R6: In write direction, each byte (MSB first, sampled on rising SCL) pulses `wr_valid_o` once with the byte on `wr_data_o`. The block acknowledges it in the 9th clock.
- R7: In read direction, the byte on `rd_data_i` is sent MSB first. A 0 pulls SDA low, a 1 releases it, and the driven value changes only while SCL is low.
- R8: `rd_req_o` pulses on the rising SCL edge of the address acknowledge in a read, and on the rising edge of each 9th clock in which the master acknowledges. After a master non-acknowledge the block releases SDA and drives nothing until START or STOP.
- R9: A repeated START in the middle of a byte discards the partial byte, with no strobe. The block then receives a fresh address byte.
- R10: A STOP releases SDA at once and returns the block to idle. Later traffic without a START is ignored.
- R11: A pulse on SCL that lasts one system clock is filtered out and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Address straps (bits [3:1] of the address byte) |
| rd_data_i | input | 8 | Next byte to transmit, held valid after `rd_req_o` |
| sda_pull_o | output | 1 | Enable for the SDA pull-down, 1 pulls low |
| target_o | output | 1 | Selected space: 0 sensor registers, 1 memory |
| rw_o | output | 1 | Direction of the current transfer, 1 read |
| addr_hit_o | output | 1 | One-cycle pulse on address match |
| wr_valid_o | output | 1 | One-cycle pulse, received byte on `wr_data_o` |
| wr_data_o | output | 8 | Last received write byte |
| rd_req_o | output | 1 | One-cycle request for the next byte to transmit |

## Verification
The bench aims at the points where a slave on a shared bus most easily goes wrong. A block that reacted to clocks before a START, or that took a wrong prefix or strap, would pull SDA in a 9th clock that belongs to another device. A repeated START placed after four data bits shows whether a partial byte leaks out as a write strobe, or whether the bit counter fails to clear so the next address is shifted wrongly. In a read that ends with a non-acknowledge, a following byte is clocked to prove that SDA stays released. Single-clock glitches on SCL inside a write byte would shift in extra bits if the filter did not work.

// File: rtl/i2c_dts_pkg.sv
package i2c_dts_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PFX_W   = 4;
  localparam int unsigned STRAP_W = BYTE_W - 1 - PFX_W;
  localparam int unsigned CNT_W   = $clog2(BYTE_W);

  localparam logic [PFX_W-1:0] TEMP_PFX = 4'b0011;
  localparam logic [PFX_W-1:0] MEM_PFX  = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK_W,
    ST_AACK,
    ST_WDATA,
    ST_WACK_W,
    ST_WACK,
    ST_RDATA,
    ST_MACK_W,
    ST_MACK,
    ST_HOLD
  } state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned SYNC_N  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  // SYNC_N synchronizer flops plus one history flop for the 2-sample vote
  logic [SYNC_N:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {(SYNC_N+1){RST_VAL}};
      line_o  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[SYNC_N-1:0], line_i};
      if (chain_q[SYNC_N] == chain_q[SYNC_N-1]) line_o <= chain_q[SYNC_N];
    end
  end
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign scl_rise_o = scl_f_i & ~scl_q;
  assign scl_fall_o = ~scl_f_i & scl_q;
  assign start_o    = scl_q & scl_f_i & sda_q & ~sda_f_i;
  assign stop_o     = scl_q & scl_f_i & ~sda_q & sda_f_i;
endmodule

// File: rtl/i2c_dts_engine.sv
module i2c_dts_engine
  import i2c_dts_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sda_f_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_pull_o,
  output logic               target_o,
  output logic               rw_o,
  output logic               addr_hit_o,
  output logic               wr_valid_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               rd_req_o
);
  state_e             st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-2:0]  rx_q;
  logic [BYTE_W-2:0]  tx_q;
  logic               macked_q;

  logic [BYTE_W-1:0] rx_byte;
  logic [PFX_W-1:0]  pfx;
  logic              last_bit, addr_ok;

  assign rx_byte  = {rx_q, sda_f_i};
  assign pfx      = rx_byte[BYTE_W-1 -: PFX_W];
  assign last_bit = (cnt_q == CNT_W'(BYTE_W-1));
  assign addr_ok  = ((pfx == TEMP_PFX) || (pfx == MEM_PFX)) && (rx_byte[STRAP_W:1] == strap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      macked_q   <= 1'b0;
      sda_pull_o <= 1'b0;
      target_o   <= 1'b0;
      rw_o       <= 1'b0;
      addr_hit_o <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
      rd_req_o   <= 1'b0;
    end else begin
      addr_hit_o <= 1'b0;
      wr_valid_o <= 1'b0;
      rd_req_o   <= 1'b0;
      if (stop_i) begin
        st_q       <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_i) begin
        st_q       <= ST_ADDR;
        cnt_q      <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: if (scl_rise_i) begin
            rx_q <= rx_byte[BYTE_W-2:0];
            if (last_bit) begin
              if (addr_ok) begin
                addr_hit_o <= 1'b1;
                target_o   <= (pfx == MEM_PFX);
                rw_o       <= rx_byte[0];
                st_q       <= ST_AACK_W;
              end else begin
                st_q <= ST_HOLD;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_AACK_W: if (scl_fall_i) begin
            sda_pull_o <= 1'b1;
            st_q       <= ST_AACK;
          end
          ST_AACK: begin
            if (scl_rise_i && rw_o) rd_req_o <= 1'b1;
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_o) begin
                tx_q       <= rd_data_i[BYTE_W-2:0];
                sda_pull_o <= ~rd_data_i[BYTE_W-1];
                st_q       <= ST_RDATA;
              end else begin
                sda_pull_o <= 1'b0;
                st_q       <= ST_WDATA;
              end
            end
          end
          ST_WDATA: if (scl_rise_i) begin
            rx_q <= rx_byte[BYTE_W-2:0];
            if (last_bit) begin
              wr_valid_o <= 1'b1;
              wr_data_o  <= rx_byte;
              st_q       <= ST_WACK_W;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_WACK_W: if (scl_fall_i) begin
            sda_pull_o <= 1'b1;
            st_q       <= ST_WACK;
          end
          ST_WACK: if (scl_fall_i) begin
            sda_pull_o <= 1'b0;
            cnt_q      <= '0;
            st_q       <= ST_WDATA;
          end
          ST_RDATA: begin
            if (scl_fall_i) begin
              sda_pull_o <= ~tx_q[BYTE_W-2];
              tx_q       <= {tx_q[BYTE_W-3:0], 1'b0};
            end
            if (scl_rise_i) begin
              if (last_bit) st_q <= ST_MACK_W;
              else          cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_MACK_W: if (scl_fall_i) begin
            sda_pull_o <= 1'b0;
            st_q       <= ST_MACK;
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              macked_q <= ~sda_f_i;
              if (!sda_f_i) rd_req_o <= 1'b1;
            end
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (macked_q) begin
                tx_q       <= rd_data_i[BYTE_W-2:0];
                sda_pull_o <= ~rd_data_i[BYTE_W-1];
                st_q       <= ST_RDATA;
              end else begin
                st_q <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_dual_target_slave.sv
module i2c_dual_target_slave
  import i2c_dts_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_pull_o,
  output logic               target_o,
  output logic               rw_o,
  output logic               addr_hit_o,
  output logic               wr_valid_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               rd_req_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] line_raw, line_f;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  assign line_raw = {sda_i, scl_i};
  assign scl_f    = line_f[0];
  assign sda_f    = line_f[1];

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_line_filter #(.SYNC_N(SYNC_N), .RST_VAL(1'b1)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_raw[g]),
      .line_o (line_f[g])
    );
  end

  i2c_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_f_i    (scl_f),
    .sda_f_i    (sda_f),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  i2c_dts_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_f_i    (sda_f),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .strap_i    (strap_i),
    .rd_data_i  (rd_data_i),
    .sda_pull_o (sda_pull_o),
    .target_o   (target_o),
    .rw_o       (rw_o),
    .addr_hit_o (addr_hit_o),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o),
    .rd_req_o   (rd_req_o)
  );
endmodule

// File: rtl/i2c_dts_chk.sv
module i2c_dts_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_f,
  input logic start_evt,
  input logic stop_evt,
  input logic sda_pull_o,
  input logic addr_hit_o,
  input logic wr_valid_o,
  input logic rd_req_o
);
  // R7
  pull_rise_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_f);

  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !sda_pull_o);

  // R9
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> !sda_pull_o);

  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({addr_hit_o, wr_valid_o, rd_req_o}));

  // R6
  wr_on_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> scl_f);

  // R8
  rdreq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
endmodule

bind i2c_dual_target_slave i2c_dts_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_f      (scl_f),
  .start_evt  (start_evt),
  .stop_evt   (stop_evt),
  .sda_pull_o (sda_pull_o),
  .addr_hit_o (addr_hit_o),
  .wr_valid_o (wr_valid_o),
  .rd_req_o   (rd_req_o)
);

// File: tb/i2c_dual_target_slave_bench.sv
`timescale 1ns/1ps
module i2c_dual_target_slave_bench;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] rd_data = 8'h00;
  logic sda_pull, target, rw, addr_hit, wr_valid, rd_req;
  logic [7:0] wr_data;
  wire  sda_bus = sda_m & ~sda_pull;

  always #10 clk = ~clk;

  i2c_dual_target_slave u_i2c_dual_target_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(STRAP), .rd_data_i(rd_data), .sda_pull_o(sda_pull),
    .target_o(target), .rw_o(rw), .addr_hit_o(addr_hit),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data), .rd_req_o(rd_req)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit chk_en = 0;
  logic exp_pull = 1'b0;
  string chk_tag = "";

  // reference back end / observation
  logic [7:0] wr_q[$];
  int hit_cnt = 0, wr_cnt = 0, req_cnt = 0, rd_k = 0;
  logic last_tgt = 1'b0, last_rw = 1'b0;

  function automatic logic [7:0] rd_val(int k);
    return 8'hC6 ^ 8'(k * 59);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (addr_hit) begin hit_cnt++; last_tgt = target; last_rw = rw; end
      if (wr_valid) begin wr_cnt++; wr_q.push_back(wr_data); end
      if (rd_req) begin req_cnt++; rd_data <= rd_val(rd_k); rd_k++; end
    end
    if (chk_en) begin
      n_chk++;
      if (sda_pull !== exp_pull) begin
        n_fail++;
        $display("FAIL %s pull act=%0b exp=%0b", chk_tag, sda_pull, exp_pull);
      end
    end
  end

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  // one SCL clock; entry and exit with SCL low
  task automatic bit_clk(input logic m_bit, input logic e_pull, input string tag,
                         input bit glitch, output logic seen);
    sda_m = m_bit;
    if (glitch) begin
      wq(3); scl_m = 1'b1; wq(1); scl_m = 1'b0; wq(Q - 4);
    end else wq();
    scl_m = 1'b1;
    wq(Q / 2);
    exp_pull = e_pull; chk_tag = tag; chk_en = 1;
    wq(Q);
    seen = sda_bus;
    chk_en = 0;
    wq(Q / 2);
    scl_m = 1'b0;
    wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic e_ack, input string tag,
                           input bit glitch = 0);
    logic s;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], 1'b0, tag, glitch, s);
    bit_clk(1'b1, e_ack, tag, 1'b0, s);
  endtask

  task automatic read_byte(input logic [7:0] e, input logic m_ack, input string tag);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, ~e[i], tag, 1'b0, s);
      got[i] = s;
    end
    check(got == e, tag, got, e);
    bit_clk(~m_ack, 1'b0, tag, 1'b0, s);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2 * Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic s;
    int h0, w0, r0;
    wq(5);
    // R1: reset state
    check(sda_pull == 0 && addr_hit == 0 && wr_valid == 0 && rd_req == 0, "R1 reset",
          {sda_pull, addr_hit, wr_valid, rd_req}, 0);
    rst_n = 1'b1;
    wq(5);
    check(sda_pull == 0, "R1 idle pull", sda_pull, 0);

    // R2: traffic before any START is ignored
    scl_m = 1'b0; wq();
    send_byte(8'h3A, 1'b0, "R2 no-start addr");
    send_byte(8'h55, 1'b0, "R2 no-start data");
    check(hit_cnt == 0 && wr_cnt == 0, "R2 no strobes", hit_cnt + wr_cnt, 0);

    // R3 + R6: sensor target write of two bytes
    bus_start();
    send_byte({4'b0011, STRAP, 1'b0}, 1'b1, "R3 addr ack");
    check(hit_cnt == 1, "R3 hit count", hit_cnt, 1);
    check(last_tgt == 1'b0 && last_rw == 1'b0, "R3 target/rw", {last_tgt, last_rw}, 0);
    send_byte(8'h5C, 1'b1, "R6 data ack 0");
    send_byte(8'hA3, 1'b1, "R6 data ack 1");
    bus_stop();
    check(wr_cnt == 2, "R6 write count", wr_cnt, 2);
    check(wr_q.size() == 2 && wr_q[0] == 8'h5C && wr_q[1] == 8'hA3, "R6 write data",
          wr_q.size() == 2 ? {wr_q[0], wr_q[1]} : 0, 16'h5CA3);
    wr_q.delete();

    // R4 + R7 + R8: memory target read, ack, ack, nack
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, 1'b1, "R4 addr ack");
    check(last_tgt == 1'b1 && last_rw == 1'b1, "R4 target/rw", {last_tgt, last_rw}, 3);
    read_byte(rd_val(0), 1'b1, "R7 read byte 0");
    read_byte(rd_val(1), 1'b1, "R7 read byte 1");
    read_byte(rd_val(2), 1'b0, "R7 read byte 2");
    check(req_cnt == 3, "R8 request count", req_cnt, 3);
    for (int i = 0; i < 8; i++) bit_clk(1'b1, 1'b0, "R8 released after nack", 1'b0, s);
    check(req_cnt == 3, "R8 no request after nack", req_cnt, 3);
    bus_stop();

    // R5: bad prefix, then strap mismatch
    h0 = hit_cnt; w0 = wr_cnt;
    bus_start();
    send_byte({4'b0111, STRAP, 1'b0}, 1'b0, "R5 bad prefix");
    send_byte(8'h00, 1'b0, "R5 data after bad prefix");
    bus_stop();
    bus_start();
    send_byte({4'b0011, 3'b100, 1'b0}, 1'b0, "R5 strap mismatch");
    send_byte(8'hFF, 1'b0, "R5 data after mismatch");
    bus_stop();
    check(hit_cnt == h0 && wr_cnt == w0, "R5 no strobes", hit_cnt - h0 + wr_cnt - w0, 0);

    // R9: repeated START after four data bits
    bus_start();
    send_byte({4'b0011, STRAP, 1'b0}, 1'b1, "R9 first addr");
    for (int i = 0; i < 4; i++) bit_clk(1'(i), 1'b0, "R9 partial", 1'b0, s);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, 1'b1, "R9 new addr ack");
    check(last_tgt == 1'b1, "R9 new target", last_tgt, 1);
    send_byte(8'h11, 1'b1, "R9 data ack");
    bus_stop();
    check(wr_q.size() == 1 && wr_q[0] == 8'h11, "R9 only full byte",
          wr_q.size() == 1 ? wr_q[0] : 8'hEE, 8'h11);
    wr_q.delete();

    // R11: one-clock SCL glitches inside a write byte
    bus_start();
    send_byte({4'b0011, STRAP, 1'b0}, 1'b1, "R11 addr");
    send_byte(8'h96, 1'b1, "R11 glitched data ack", 1'b1);
    bus_stop();
    check(wr_q.size() == 1 && wr_q[0] == 8'h96, "R11 glitch data",
          wr_q.size() == 1 ? wr_q[0] : 8'hEE, 8'h96);
    wr_q.delete();

    // R10: STOP right after address, then traffic without START
    bus_start();
    send_byte({4'b0011, STRAP, 1'b0}, 1'b1, "R10 addr");
    bus_stop();
    check(sda_pull == 0, "R10 released", sda_pull, 0);
    h0 = hit_cnt; w0 = wr_cnt; r0 = req_cnt;
    scl_m = 1'b0; wq();
    send_byte({4'b1010, STRAP, 1'b0}, 1'b0, "R10 ignored after stop");
    scl_m = 1'b1; wq();
    check(hit_cnt == h0 && wr_cnt == w0 && req_cnt == r0, "R10 idle no strobes",
          hit_cnt - h0, 0);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule